// File: doc/BRIEF.md
# Low-Power Compare-Match Timer

This block is a small periodic timer for a low-power domain. A slow tick arrives as one of several single-cycle input strobes. A source-select field picks one of them. An optional power-of-two divider thins that tick into a count strobe. A 16-bit up-counter advances once per count strobe. When the counter meets the programmed compare value, a status flag is raised and the counter starts again from zero. The result is a steady periodic event with a period of compare+1 count strobes.

Software reaches the timer through four 32-bit words on a simple synchronous register bus. Writes are single-cycle and reads are combinational. The words hold:

- control and status,
- clock routing (source select, bypass and divider),
- the compare value,
- a read-only view of the current count.

The interrupt output is a level. It stays high for as long as the sticky flag and its enable are both set, so a handler must clear the flag by writing 1 to it.

Top module: `lpcm_timer`

## Requirements
- R1: After reset every register word reads zero and `irq_o` is low.
- R2: Word 0x00 (control) holds the run enable in bit 0, the interrupt enable in bit 6 and the compare flag in bit 7. Bits 0 and 6 read back as written.
- R3: Word 0x04 (clock routing) uses bits [1:0] for source select, bit 2 for bypass and bits [6:3] for the divide exponent N. With bypass set and the timer running, the count rises by exactly one for each tick on the selected source. Ticks on the other sources have no effect.
- R4: With bypass clear, the count advances once per 2^(N+1) ticks of the selected source.
- R5: When a count strobe arrives while the count equals the compare value (word 0x08, bits [15:0]), the count returns to 0 and the flag becomes 1. The result is a period of compare+1 strobes.
- R6: `irq_o` is high exactly while the flag and the interrupt enable are both 1. It stays high across further strobes until the flag is cleared.
- R7: A write to control with bit 7 set clears the flag, and the other control bits take their written values. A write with bit 7 clear leaves the flag unchanged. A match in the same cycle as a clearing write wins, and the flag stays 1.
- R8: While the run enable is 0, the count and the divider are held at zero and ticks are ignored. The flag keeps its value.
- R9: Writes to the count word (0x0C) and to unmapped words (index 4 and above) change nothing. Unmapped words read zero, and the compare and routing words read back as written.
- R10: If the compare value is lowered below the current count, the count keeps rising and wraps from 0xFFFF to 0 without setting the flag. It then matches on its way back up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_tick_i | input | NUM_SRC | Single-cycle tick strobes, one per selectable source |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Byte address of the register word |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Read data for `reg_addr_i`, combinational |
| irq_o | output | 1 | Level interrupt: flag AND interrupt enable |

## Verification
The bench builds the timer with its defaults:

- four sources,
- a 4-bit divide exponent,
- a 16-bit counter,
- a 5-bit address, so words at index 4 and above exist and can be checked as unmapped.

Holding the selected tick high on every cycle drives the counter through its full 16-bit wrap in about 65 thousand cycles. That puts the lowered-compare case of R10 within reach. The small divide exponents 0 and 1 exercise the divider's terminal count and its reset on disable. Writing a clear in the same cycle as a match shows which of the two takes priority on the flag.

// File: rtl/lpcm_pkg.sv
package lpcm_pkg;
   // word indices (byte address / 4)
   localparam int unsigned IDX_CTRL = 0;
   localparam int unsigned IDX_ROUTE = 1;
   localparam int unsigned IDX_CMP = 2;
   localparam int unsigned IDX_COUNT = 3;
   localparam int unsigned NUM_WORDS = 4;

   // control word bit positions
   localparam int unsigned CTRL_RUN_BIT = 0;
   localparam int unsigned CTRL_IE_BIT = 6;
   localparam int unsigned CTRL_FLAG_BIT = 7;

   typedef enum logic [1:0] {
      WR_NONE = 2'd0,
      WR_CTRL = 2'd1,
      WR_ROUTE = 2'd2,
      WR_CMP = 2'd3
   } wr_kind_e;
endpackage

// File: rtl/lpcm_prescaler.sv
module lpcm_prescaler #(
   parameter int unsigned NUM_SRC = 4,
   parameter int unsigned PRE_W = 4,
   parameter bit HAS_DIV = 1'b1,
   localparam int unsigned SEL_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
   localparam int unsigned DIV_W = 1 << PRE_W
) (
   input logic clk,
   input logic rst_n,
   input logic en_i,
   input logic [SEL_W-1:0] sel_i,
   input logic bypass_i,
   input logic [PRE_W-1:0] pre_i,
   input logic [NUM_SRC-1:0] src_tick_i,
   output logic strobe_o
);
   logic tick_sel;

   // source selection: direct index when every code names a source
   if (NUM_SRC == (1 << SEL_W)) begin : g_sel_full
      assign tick_sel = src_tick_i[sel_i];
   end else begin : g_sel_guard
      always_comb begin
         tick_sel = 1'b0;
         for (int i = 0; i < NUM_SRC; i++) begin
            if (32'(sel_i) == i) tick_sel = src_tick_i[i];
         end
      end
   end

   if (HAS_DIV) begin : g_div
      logic [DIV_W-1:0] div_q;
      logic [DIV_W:0] pow_w;
      logic [DIV_W-1:0] lim_w;
      logic at_lim;

      assign pow_w = (DIV_W + 1)'(1) << ((DIV_W + 1)'(pre_i) + 1'b1);
      assign lim_w = pow_w[DIV_W-1:0] - 1'b1;
      assign at_lim = (div_q >= lim_w);

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            div_q <= '0;
         end else if (!en_i) begin
            div_q <= '0;
         end else if (tick_sel && !bypass_i) begin
            if (at_lim) div_q <= '0;
            else div_q <= div_q + 1'b1;
         end
      end

      assign strobe_o = en_i && tick_sel && (bypass_i || at_lim);

      assert_div_clear_R8 : assert property (@(posedge clk) disable iff (!rst_n)
         !en_i |=> div_q == '0);
      assert_div_step_R4 : assert property (@(posedge clk) disable iff (!rst_n)
         (en_i && tick_sel && !bypass_i && !at_lim) |=> div_q == $past(div_q) + 1'b1);
      assert_div_idle_R4 : assert property (@(posedge clk) disable iff (!rst_n)
         (en_i && !tick_sel) |=> $stable(div_q));
   end else begin : g_nodiv
      logic unused_pre;
      assign unused_pre = ^{pre_i, bypass_i};
      assign strobe_o = en_i && tick_sel;
   end

   assert_strobe_src_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      strobe_o |-> (en_i && src_tick_i != '0));
endmodule

// File: rtl/lpcm_counter.sv
module lpcm_counter #(
   parameter int unsigned CNT_W = 16
) (
   input logic clk,
   input logic rst_n,
   input logic en_i,
   input logic strobe_i,
   input logic [CNT_W-1:0] cmp_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic match_o
);
   logic [CNT_W-1:0] cnt_q;
   logic hit;

   assign hit = (cnt_q == cmp_i);
   assign match_o = en_i && strobe_i && hit;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!en_i) begin
         cnt_q <= '0;
      end else if (strobe_i) begin
         if (hit) cnt_q <= '0;
         else cnt_q <= cnt_q + 1'b1;
      end
   end

   assign cnt_o = cnt_q;

   assert_cnt_step_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && strobe_i && cnt_q != cmp_i) |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));
   assert_cnt_hold_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && !strobe_i) |=> $stable(cnt_q));
   assert_restart_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && strobe_i && cnt_q == cmp_i) |=> cnt_q == '0);
   assert_cnt_clear_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |=> cnt_q == '0);
endmodule

// File: rtl/lpcm_regs.sv
module lpcm_regs
   import lpcm_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 5,
   parameter int unsigned CNT_W = 16,
   parameter int unsigned SEL_W = 2,
   parameter int unsigned PRE_W = 4,
   localparam int unsigned IDX_W = ADDR_W - 2,
   localparam int unsigned BYP_BIT = SEL_W,
   localparam int unsigned PRE_LSB = SEL_W + 1
) (
   input logic clk,
   input logic rst_n,
   input logic reg_wr_i,
   input logic [ADDR_W-1:0] reg_addr_i,
   input logic [DATA_W-1:0] reg_wdata_i,
   output logic [DATA_W-1:0] reg_rdata_o,
   input logic match_i,
   input logic [CNT_W-1:0] cnt_i,
   output logic run_o,
   output logic ie_o,
   output logic flag_o,
   output logic [SEL_W-1:0] sel_o,
   output logic bypass_o,
   output logic [PRE_W-1:0] pre_o,
   output logic [CNT_W-1:0] cmp_o
);
   logic [IDX_W-1:0] idx;
   wr_kind_e wr_kind;
   logic run_q, ie_q, flag_q, byp_q;
   logic [SEL_W-1:0] sel_q;
   logic [PRE_W-1:0] pre_q;
   logic [CNT_W-1:0] cmp_q;
   logic clr_req;
   logic unused_bus;

   assign idx = reg_addr_i[ADDR_W-1:2];
   assign unused_bus = ^{reg_addr_i[1:0], reg_wdata_i};

   always_comb begin
      wr_kind = WR_NONE;
      if (reg_wr_i) begin
         case (32'(idx))
            IDX_CTRL: wr_kind = WR_CTRL;
            IDX_ROUTE: wr_kind = WR_ROUTE;
            IDX_CMP: wr_kind = WR_CMP;
            default: wr_kind = WR_NONE;
         endcase
      end
   end

   assign clr_req = (wr_kind == WR_CTRL) && reg_wdata_i[CTRL_FLAG_BIT];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q <= 1'b0;
         ie_q <= 1'b0;
         byp_q <= 1'b0;
         sel_q <= '0;
         pre_q <= '0;
         cmp_q <= '0;
      end else begin
         case (wr_kind)
            WR_CTRL: begin
               run_q <= reg_wdata_i[CTRL_RUN_BIT];
               ie_q <= reg_wdata_i[CTRL_IE_BIT];
            end
            WR_ROUTE: begin
               sel_q <= reg_wdata_i[SEL_W-1:0];
               byp_q <= reg_wdata_i[BYP_BIT];
               pre_q <= reg_wdata_i[PRE_LSB +: PRE_W];
            end
            WR_CMP: cmp_q <= reg_wdata_i[CNT_W-1:0];
            default: ;
         endcase
      end
   end

   // sticky flag: a match outranks a clearing write
   always_ff @(posedge clk) begin
      if (!rst_n) flag_q <= 1'b0;
      else if (match_i) flag_q <= 1'b1;
      else if (clr_req) flag_q <= 1'b0;
   end

   always_comb begin
      reg_rdata_o = '0;
      case (32'(idx))
         IDX_CTRL: begin
            reg_rdata_o[CTRL_RUN_BIT] = run_q;
            reg_rdata_o[CTRL_IE_BIT] = ie_q;
            reg_rdata_o[CTRL_FLAG_BIT] = flag_q;
         end
         IDX_ROUTE: begin
            reg_rdata_o[SEL_W-1:0] = sel_q;
            reg_rdata_o[BYP_BIT] = byp_q;
            reg_rdata_o[PRE_LSB +: PRE_W] = pre_q;
         end
         IDX_CMP: reg_rdata_o[CNT_W-1:0] = cmp_q;
         IDX_COUNT: reg_rdata_o[CNT_W-1:0] = cnt_i;
         default: reg_rdata_o = '0;
      endcase
   end

   assign run_o = run_q;
   assign ie_o = ie_q;
   assign flag_o = flag_q;
   assign sel_o = sel_q;
   assign bypass_o = byp_q;
   assign pre_o = pre_q;
   assign cmp_o = cmp_q;

   assert_flag_set_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      match_i |=> flag_q);
   assert_flag_w1c_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      (clr_req && !match_i) |=> !flag_q);
   assert_flag_hold_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_req && !match_i) |=> $stable(flag_q));
   assert_cmp_stable_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      (wr_kind != WR_CMP) |=> $stable(cmp_q));
endmodule

// File: rtl/lpcm_timer.sv
module lpcm_timer #(
   parameter int unsigned NUM_SRC = 4,
   parameter int unsigned PRE_W = 4,
   parameter int unsigned CNT_W = 16,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 5,
   parameter bit HAS_DIV = 1'b1,
   localparam int unsigned SEL_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
   input logic clk,
   input logic rst_n,
   input logic [NUM_SRC-1:0] src_tick_i,
   input logic reg_wr_i,
   input logic [ADDR_W-1:0] reg_addr_i,
   input logic [DATA_W-1:0] reg_wdata_i,
   output logic [DATA_W-1:0] reg_rdata_o,
   output logic irq_o
);
   // elaboration-time parameter checks
   if (CNT_W > DATA_W) begin : g_chk_cnt
      $error("lpcm_timer: CNT_W must fit in DATA_W");
   end
   if (DATA_W < 8) begin : g_chk_data
      $error("lpcm_timer: control word needs at least 8 bits");
   end
   if (SEL_W + 1 + PRE_W > DATA_W) begin : g_chk_route
      $error("lpcm_timer: routing fields exceed DATA_W");
   end
   if (ADDR_W < 4) begin : g_chk_addr
      $error("lpcm_timer: ADDR_W too small for four words");
   end
   if (PRE_W < 1 || PRE_W > 5) begin : g_chk_pre
      $error("lpcm_timer: PRE_W must be 1 to 5");
   end

   logic run, ie, flag, bypass, strobe, match;
   logic [SEL_W-1:0] sel;
   logic [PRE_W-1:0] pre;
   logic [CNT_W-1:0] cmp, cnt;

   lpcm_regs #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W),
      .SEL_W(SEL_W), .PRE_W(PRE_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i),
      .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
      .match_i(match), .cnt_i(cnt),
      .run_o(run), .ie_o(ie), .flag_o(flag),
      .sel_o(sel), .bypass_o(bypass), .pre_o(pre), .cmp_o(cmp)
   );

   lpcm_prescaler #(
      .NUM_SRC(NUM_SRC), .PRE_W(PRE_W), .HAS_DIV(HAS_DIV)
   ) u_pre (
      .clk(clk), .rst_n(rst_n), .en_i(run),
      .sel_i(sel), .bypass_i(bypass), .pre_i(pre),
      .src_tick_i(src_tick_i), .strobe_o(strobe)
   );

   lpcm_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .en_i(run), .strobe_i(strobe),
      .cmp_i(cmp), .cnt_o(cnt), .match_o(match)
   );

   assign irq_o = flag && ie;

   assert_irq_hold_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && !(reg_wr_i && reg_addr_i[ADDR_W-1:2] == '0)) |=> irq_o);
   assert_irq_off_R1 : assert property (@(posedge clk)
      !rst_n |=> !irq_o);
endmodule

// File: tb/sim_lpcm_timer.sv
`timescale 1ns/1ps
module sim_lpcm_timer;
   localparam int unsigned NUM_SRC = 4;
   localparam int unsigned ADDR_W = 5;
   localparam logic [4:0] A_CTRL = 5'h00, A_ROUTE = 5'h04, A_CMP = 5'h08,
                          A_CNT = 5'h0C, A_BAD = 5'h10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NUM_SRC-1:0] src_tick = '0;
   logic reg_wr = 1'b0;
   logic [ADDR_W-1:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic irq;

   always #2.5 clk = ~clk;

   lpcm_timer u0 (
      .clk(clk), .rst_n(rst_n), .src_tick_i(src_tick),
      .reg_wr_i(reg_wr), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
      .reg_rdata_o(reg_rdata), .irq_o(irq)
   );

   typedef struct {
      bit is_irq;
      logic [31:0] exp;
      string tag;
   } item_t;

   item_t sb[$];
   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // monitor: pops expected items and compares in the low clock phase
   initial begin
      forever begin
         @(negedge clk);
         #1;
         while (sb.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = sb.pop_front();
            act = it.is_irq ? {31'd0, irq} : reg_rdata;
            checks++;
            if (act !== it.exp) begin
               errors++;
               $display("FAIL %s: actual=0x%0h expected=0x%0h", it.tag, act, it.exp);
            end
         end
      end
   end

   task automatic chk(input logic [4:0] a, input logic [31:0] e, input string tag);
      item_t it;
      @(negedge clk);
      reg_addr = a;
      it.is_irq = 1'b0; it.exp = e; it.tag = tag;
      sb.push_back(it);
   endtask

   task automatic chk_irq(input logic e, input string tag);
      item_t it;
      @(negedge clk);
      it.is_irq = 1'b1; it.exp = {31'd0, e}; it.tag = tag;
      sb.push_back(it);
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic pulse(input int src, input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         src_tick = NUM_SRC'(1) << src;
         @(negedge clk);
         src_tick = '0;
      end
   endtask

   task automatic hold(input int n);
      @(negedge clk);
      src_tick = 4'b0001;
      repeat (n) @(negedge clk);
      src_tick = '0;
   endtask

   task automatic wr_with_tick(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d; src_tick = 4'b0001;
      @(negedge clk);
      reg_wr = 1'b0; src_tick = '0;
   endtask

   // watchdog
   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      chk(A_CTRL, 32'h0, "R1 ctrl");
      chk(A_ROUTE, 32'h0, "R1 route");
      chk(A_CMP, 32'h0, "R1 cmp");
      chk(A_CNT, 32'h0, "R1 count");
      chk_irq(1'b0, "R1 irq");
      // R2 control readback
      wr(A_CTRL, 32'h41);
      chk(A_CTRL, 32'h41, "R2 ctrl readback");
      wr(A_ROUTE, 32'h04);
      wr(A_CMP, 32'd3);
      // R3 other sources ignored, selected advances
      pulse(1, 3);
      chk(A_CNT, 32'd0, "R3 unselected source");
      pulse(0, 2);
      chk(A_CNT, 32'd2, "R3 bypass step");
      pulse(0, 1);
      chk(A_CNT, 32'd3, "R5 at compare");
      chk(A_CTRL, 32'h41, "R5 no flag before strobe");
      pulse(0, 1);
      chk(A_CNT, 32'd0, "R5 restart");
      chk(A_CTRL, 32'hC1, "R5 flag set");
      chk_irq(1'b1, "R6 irq high");
      pulse(0, 1);
      chk(A_CNT, 32'd1, "R5 after restart");
      chk_irq(1'b1, "R6 irq stays");
      // R7 write without bit 7 keeps flag, with bit 7 clears
      wr(A_CTRL, 32'h41);
      chk(A_CTRL, 32'hC1, "R7 zero write keeps flag");
      wr(A_CTRL, 32'hC1);
      chk(A_CTRL, 32'h41, "R7 w1c");
      chk_irq(1'b0, "R6 irq low after clear");
      chk(A_CNT, 32'd1, "R7 count untouched");
      // R8 disable clears count, keeps flag
      pulse(0, 3);
      chk(A_CTRL, 32'hC1, "R5 second period");
      pulse(0, 1);
      wr(A_CTRL, 32'h40);
      chk(A_CNT, 32'd0, "R8 count cleared");
      chk(A_CTRL, 32'hC0, "R8 flag kept");
      chk_irq(1'b1, "R8 irq kept");
      pulse(0, 2);
      chk(A_CNT, 32'd0, "R8 ticks ignored");
      // R7 set beats clear
      wr(A_CTRL, 32'hC1);
      chk(A_CTRL, 32'h41, "R7 clear and run");
      pulse(0, 3);
      wr_with_tick(A_CTRL, 32'hC1);
      chk(A_CTRL, 32'hC1, "R7 match wins over clear");
      chk(A_CNT, 32'd0, "R7 match restart");
      // R4 divider
      wr(A_CTRL, 32'h80);
      chk(A_CTRL, 32'h0, "R7 clear and stop");
      wr(A_ROUTE, 32'h08);
      chk(A_ROUTE, 32'h08, "R9 route readback");
      wr(A_CMP, 32'd100);
      wr(A_CTRL, 32'h01);
      pulse(0, 3);
      chk(A_CNT, 32'd0, "R4 N=1 three ticks");
      pulse(0, 1);
      chk(A_CNT, 32'd1, "R4 N=1 fourth tick");
      pulse(0, 4);
      chk(A_CNT, 32'd2, "R4 N=1 eighth tick");
      wr(A_CTRL, 32'h00);
      wr(A_ROUTE, 32'h00);
      wr(A_CTRL, 32'h01);
      pulse(0, 1);
      chk(A_CNT, 32'd0, "R4 N=0 one tick");
      pulse(0, 1);
      chk(A_CNT, 32'd1, "R4 N=0 two ticks");
      // R9 ignored writes
      wr(A_CNT, 32'h1234);
      chk(A_CNT, 32'd1, "R9 count write ignored");
      wr(A_BAD, 32'hFFFF_FFFF);
      chk(A_BAD, 32'h0, "R9 unmapped reads zero");
      chk(A_CMP, 32'd100, "R9 cmp untouched");
      chk(A_CTRL, 32'h01, "R9 ctrl untouched");
      chk(A_ROUTE, 32'h00, "R9 route untouched");
      // R10 compare below count
      wr(A_CTRL, 32'h00);
      wr(A_ROUTE, 32'h04);
      wr(A_CTRL, 32'h01);
      pulse(0, 6);
      chk(A_CNT, 32'd6, "R10 setup");
      wr(A_CMP, 32'd2);
      hold(65530);
      chk(A_CNT, 32'd0, "R10 wrapped");
      chk(A_CTRL, 32'h01, "R10 no flag on wrap");
      pulse(0, 2);
      chk(A_CNT, 32'd2, "R10 at compare");
      pulse(0, 1);
      chk(A_CTRL, 32'h81, "R10 match after wrap");
      chk_irq(1'b0, "R6 no irq without enable");
      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule